// File: doc/BRIEF.md
# Pausable Seconds Countdown Timer

This block counts seconds downward from a preset value of 30, showing the value as two binary-coded decimal digits. A divider on the system clock produces one enable pulse per second. A two-state machine gates the count: each clean single-cycle pulse on the toggle input switches between running and paused. A state LED shows which state the machine is in.

When the count reaches zero, every bit of an LED bank turns on and stays on for that whole second. On the next second the count reloads 30 and continues, so the timer repeats for as long as it runs. A synchronous reset reloads 30, forces the paused state and clears the fractional second held in the divider. Button debouncing and display driving are left to the logic around the block.

Top module: `pause_countdown_timer`

## Requirements
- R1: After reset the outputs show tens=3 and units=0, run_led is 0 and every bit of zero_leds is 0.
- R2: While running, the count drops by one every TICK_DIV clock cycles. The first drop after a start comes exactly TICK_DIV rising edges after the edge that registers the toggle pulse.
- R3: A toggle pulse that is high at a rising edge switches the state between paused and running. run_led is 1 only while running.
- R4: While paused, the count and the divider phase both hold. On resume the interrupted second finishes with only its remaining cycles, with no extra or lost decrement.
- R5: The count is two BCD digits: units stays in 0..9 and tens in 0..3. A decrement from units=0 with tens nonzero gives units=9 and tens one lower (for example 20 becomes 19).
- R6: zero_leds is all ones exactly while the count is 00, for all TICK_DIV cycles of that second, and all zeros at every other value.
- R7: The decrement after 00 loads 30 (tens=3, units=0), and counting carries on without a new toggle pulse.
- R8: Reset is synchronous and takes priority over a toggle pulse in the same cycle. It reloads 30, leaves the timer paused and clears the divider, so a following start needs a full TICK_DIV cycles before the first drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| toggle_pulse | input | 1 | Clean one-cycle pulse that switches run/pause |
| count_tens | output | 4 | BCD tens digit of the remaining seconds |
| count_units | output | 4 | BCD units digit of the remaining seconds |
| run_led | output | 1 | High while the timer is running |
| zero_leds | output | LED_COUNT | All bits high while the count is zero |

## Verification
On every cycle the embedded properties check several things: the digit ranges, the borrow from units into tens, the wrap from 00 to 30, the hold of the count between second pulses, the frozen divider while paused, the state flip on a toggle, the match between the zero flag and the digits, and the reset values. Other behaviour can only be shown by the directed scenarios, because it depends on how many cycles pass across a sequence of events. That covers the exact spacing of decrements after a start, the resumption of a paused second without an extra pulse, a zero indication that lasts a full second, and a reset that discards a partly elapsed second.

// File: rtl/timer_pkg.sv
`timescale 1ns/1ps
package timer_pkg;

   typedef enum logic {
      ST_PAUSED  = 1'b0,
      ST_RUNNING = 1'b1
   } run_state_e;

   typedef struct packed {
      logic [3:0] tens;
      logic [3:0] units;
   } bcd2_t;

   // One step down in BCD; 00 reloads the preset value
   function automatic bcd2_t bcd_step_down(bcd2_t cur, bcd2_t preset);
      bcd2_t nxt;
      if (cur.tens == 4'd0 && cur.units == 4'd0) begin
         nxt = preset;
      end else if (cur.units == 4'd0) begin
         nxt.tens  = cur.tens - 4'd1;
         nxt.units = 4'd9;
      end else begin
         nxt.tens  = cur.tens;
         nxt.units = cur.units - 4'd1;
      end
      return nxt;
   endfunction

endpackage

// File: rtl/tick_prescaler.sv
`timescale 1ns/1ps
module tick_prescaler #(
   parameter int unsigned DIV = 250_000_000
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   output logic tick
);
   localparam int unsigned CW = $clog2(DIV);
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   generate
      if (DIV < 2) begin : g_bad_div
         $error("tick_prescaler: DIV must be at least 2");
      end
   endgenerate

   logic [CW-1:0] phase_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= '0;
      end else if (en) begin
         phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
      end
   end

   assign tick = en && (phase_q == LAST);

   // R4
   paused_phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(phase_q));

   // R2
   phase_range_chk: assert property (@(posedge clk) disable iff (rst)
      phase_q <= LAST);

endmodule

// File: rtl/runpause_fsm.sv
`timescale 1ns/1ps
module runpause_fsm
   import timer_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       toggle,
   output run_state_e state_o
);
   run_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (toggle) begin
         unique case (state_q)
            ST_PAUSED:  state_d = ST_RUNNING;
            ST_RUNNING: state_d = ST_PAUSED;
            default:    state_d = ST_PAUSED;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_PAUSED;
      else     state_q <= state_d;
   end

   assign state_o = state_q;

   // R3
   toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
      toggle |=> (state_q != $past(state_q)));

   // R3
   no_toggle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !toggle |=> $stable(state_q));

endmodule

// File: rtl/bcd_down_counter.sv
`timescale 1ns/1ps
module bcd_down_counter
   import timer_pkg::*;
#(
   parameter int unsigned PRESET_TENS  = 3,
   parameter int unsigned PRESET_UNITS = 0
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       step,
   output logic [3:0] tens,
   output logic [3:0] units,
   output logic       at_zero
);
   localparam bcd2_t PRESET = '{tens: 4'(PRESET_TENS), units: 4'(PRESET_UNITS)};

   generate
      if (PRESET_TENS > 9 || PRESET_UNITS > 9) begin : g_bad_digit
         $error("bcd_down_counter: preset digits must be 0..9");
      end
      if (PRESET_TENS == 0 && PRESET_UNITS == 0) begin : g_bad_zero
         $error("bcd_down_counter: preset must be nonzero");
      end
   endgenerate

   bcd2_t cnt_q, cnt_d;
   logic  zero_q;

   always_comb begin
      cnt_d = cnt_q;
      if (step) cnt_d = bcd_step_down(cnt_q, PRESET);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= PRESET;
         zero_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_d;
         zero_q <= (cnt_d.tens == 4'd0) && (cnt_d.units == 4'd0);
      end
   end

   assign tens    = cnt_q.tens;
   assign units   = cnt_q.units;
   assign at_zero = zero_q;

   // R5
   units_range_chk: assert property (@(posedge clk) disable iff (rst)
      cnt_q.units <= 4'd9);

   // R5
   tens_range_chk: assert property (@(posedge clk) disable iff (rst)
      cnt_q.tens <= PRESET.tens);

   // R5
   borrow_chk: assert property (@(posedge clk) disable iff (rst)
      (step && cnt_q.units == 4'd0 && cnt_q.tens != 4'd0) |=>
         (cnt_q.units == 4'd9 && cnt_q.tens == $past(cnt_q.tens) - 4'd1));

   // R7
   wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (step && cnt_q.units == 4'd0 && cnt_q.tens == 4'd0) |=> (cnt_q == PRESET));

   // R2
   hold_between_steps_chk: assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(cnt_q));

   // R6
   zero_flag_match_chk: assert property (@(posedge clk) disable iff (rst)
      zero_q == (cnt_q.tens == 4'd0 && cnt_q.units == 4'd0));

endmodule

// File: rtl/pause_countdown_timer.sv
`timescale 1ns/1ps
module pause_countdown_timer
   import timer_pkg::*;
#(
   parameter int unsigned TICK_DIV     = 250_000_000,
   parameter int unsigned PRESET_TENS  = 3,
   parameter int unsigned PRESET_UNITS = 0,
   parameter int unsigned LED_COUNT    = 16
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 toggle_pulse,
   output logic [3:0]           count_tens,
   output logic [3:0]           count_units,
   output logic                 run_led,
   output logic [LED_COUNT-1:0] zero_leds
);
   generate
      if (LED_COUNT < 1) begin : g_bad_leds
         $error("pause_countdown_timer: LED_COUNT must be at least 1");
      end
   endgenerate

   run_state_e state;
   logic       running;
   logic       sec_tick;
   logic       zero_flag;

   runpause_fsm u_fsm (
      .clk     (clk),
      .rst     (rst),
      .toggle  (toggle_pulse),
      .state_o (state)
   );

   assign running = (state == ST_RUNNING);

   tick_prescaler #(.DIV(TICK_DIV)) u_prescaler (
      .clk  (clk),
      .rst  (rst),
      .en   (running),
      .tick (sec_tick)
   );

   bcd_down_counter #(
      .PRESET_TENS  (PRESET_TENS),
      .PRESET_UNITS (PRESET_UNITS)
   ) u_counter (
      .clk     (clk),
      .rst     (rst),
      .step    (sec_tick),
      .tens    (count_tens),
      .units   (count_units),
      .at_zero (zero_flag)
   );

   assign run_led = running;

   genvar gi;
   generate
      for (gi = 0; gi < LED_COUNT; gi++) begin : g_led
         assign zero_leds[gi] = zero_flag;
      end
   endgenerate

   // R8
   reset_values_chk: assert property (@(posedge clk)
      rst |=> (count_tens == 4'(PRESET_TENS) && count_units == 4'(PRESET_UNITS)
               && !run_led && zero_leds == '0));

   // R2
   paused_no_step_chk: assert property (@(posedge clk) disable iff (rst)
      !running |-> !sec_tick);

endmodule

// File: tb/pause_countdown_timer_bench.sv
`timescale 1ns/1ps
module pause_countdown_timer_bench;
   localparam int DIV  = 4;
   localparam int LEDS = 8;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            toggle_pulse = 1'b0;
   logic [3:0]      count_tens, count_units;
   logic            run_led;
   logic [LEDS-1:0] zero_leds;

   int checks = 0;
   int errors = 0;
   int exp_val = 30;
   bit done = 0;

   always #2 clk = ~clk;

   pause_countdown_timer #(.TICK_DIV(DIV), .LED_COUNT(LEDS)) u_pause_countdown_timer (
      .clk(clk), .rst(rst), .toggle_pulse(toggle_pulse),
      .count_tens(count_tens), .count_units(count_units),
      .run_led(run_led), .zero_leds(zero_leds)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic chk_count(input string req);
      chk(req, "tens", int'(count_tens), exp_val / 10);
      chk(req, "units", int'(count_units), exp_val % 10);
      chk(req, "zero_leds", int'(zero_leds), (exp_val == 0) ? (1 << LEDS) - 1 : 0);
   endtask

   task automatic press();
      @(negedge clk); toggle_pulse = 1'b1;
      @(negedge clk); toggle_pulse = 1'b0;
   endtask

   // Assumes alignment just after a decrement edge
   task automatic wait_ticks(input int n);
      repeat (n * DIV) @(posedge clk);
      #1;
      exp_val = (exp_val - n + 31 * 4) % 31;
   endtask

   task automatic test_reset();
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;
      exp_val = 30;
      chk_count("R1");
      chk("R1", "run_led", int'(run_led), 0);
   endtask

   task automatic test_paused_hold();
      repeat (20) @(posedge clk);
      #1;
      chk_count("R4");
      chk("R3", "run_led paused", int'(run_led), 0);
   endtask

   task automatic test_start();
      press();
      chk("R3", "run_led running", int'(run_led), 1);
      repeat (DIV - 1) @(posedge clk);
      #1;
      chk_count("R2");
      @(posedge clk); #1;
      exp_val = 29;
      chk_count("R2");
   endtask

   task automatic test_borrow();
      wait_ticks(9);
      chk_count("R5");
      wait_ticks(1);
      chk("R5", "tens after borrow", int'(count_tens), 1);
      chk("R5", "units after borrow", int'(count_units), 9);
   endtask

   task automatic test_pause_resume();
      repeat (2) @(posedge clk);
      press();
      chk("R3", "run_led after pause", int'(run_led), 0);
      repeat (5 * DIV) @(posedge clk);
      #1;
      chk_count("R4");
      press();
      chk_count("R4");
      @(posedge clk); #1;
      exp_val = exp_val - 1;
      chk_count("R4");
   endtask

   task automatic test_zero_wrap();
      wait_ticks(exp_val - 1);
      chk_count("R6");
      wait_ticks(1);
      chk_count("R6");
      repeat (DIV - 1) @(posedge clk);
      #1;
      chk_count("R6");
      @(posedge clk); #1;
      exp_val = 30;
      chk_count("R7");
      chk("R7", "run_led after wrap", int'(run_led), 1);
      wait_ticks(1);
      chk_count("R7");
   endtask

   task automatic test_reset_midrun();
      @(posedge clk);
      @(negedge clk); rst = 1'b1; toggle_pulse = 1'b1;
      @(negedge clk); rst = 1'b0; toggle_pulse = 1'b0;
      exp_val = 30;
      chk_count("R8");
      chk("R8", "run_led after reset", int'(run_led), 0);
      press();
      repeat (DIV - 1) @(posedge clk);
      #1;
      chk_count("R8");
      @(posedge clk); #1;
      exp_val = 29;
      chk_count("R8");
   endtask

   initial begin
      test_reset();
      test_paused_hold();
      test_start();
      test_borrow();
      test_pause_resume();
      test_zero_wrap();
      test_reset_midrun();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule